// File: doc/BRIEF.md
# Inband Loopback Code Detector

This block watches the bit stream recovered from a line receiver, one bit per strobe, and looks for two repeating inband codes. Once a controller has armed it, the block commands a remote loopback after the activate code has been present for a full qualification window. It releases that loopback after the deactivate code has been present for a full window, or when the controller asks for remote loopback by hand. The block also works out the final loopback and transmit selects from the controller's three control levels: local loopback, remote loopback and transmit all ones.

The controller presents its three control bits as levels, together with a write strobe that marks each update. Arming needs a write with all three bits set, followed by a later write with all three cleared. Local loopback only suspends a network-initiated loopback; it does not cancel it. Asking for local and remote loopback together, with all-ones clear, resets the block's state. The same pair with all-ones set is the first step of the arming sequence instead.

A code is qualified over a window of `WIN_LEN` bit periods. Each received bit is compared with the bit one code length earlier. A window passes when it ends with at most `ERR_LIMIT` such mismatches and a count of ones within `ERR_LIMIT` of the count the code should give. As soon as the mismatch count would exceed the limit, the window restarts. `WIN_LEN` must be a multiple of both code lengths, so any aligned window of a clean code holds an exact count of ones. Below, "window pass" means a window that ends while the block is armed and remote loopback is not requested.

Top module: `inband_loop_detect`

## Requirements
- R1: After reset, `armed` is 0. It goes to 1 only on the write (`ctl_wr`=1) with all three control bits 0 that directly follows a write with all three set. A write with any other combination in between cancels the sequence. While `armed` is 0, received codes never set `net_active`.
- R2: The activate code is the 5-bit pattern 0,0,0,0,1 (in transmission order) repeated. A window pass for it sets `net_active` at the clock edge that takes the window's last bit. A stream of all zeros never passes.
- R3: A window is abandoned and restarted as soon as its mismatch count (each bit against the bit one code length earlier) would exceed `ERR_LIMIT`. Isolated single-bit errors spaced one window apart still qualify. A stream corrupted every 7 bits never qualifies.
- R4: The deactivate code is the 3-bit pattern 0,0,1 repeated. A window pass for it clears `net_active` and leaves `armed` at 1.
- R5: While armed, `ctl_remote_lb`=1 clears both `net_active` and `armed` at the next clock edge. `net_active` is never 1 while `armed` is 0.
- R6: `sel_local_lb` = `ctl_local_lb` & ~`ctl_remote_lb`. `sel_remote_lb` = ~`ctl_local_lb` & (`ctl_remote_lb` | `net_active`). Local loopback therefore suspends a network loopback without clearing `net_active`, and the loopback returns when local loopback is released.
- R7: `sel_all_ones` = `ctl_all_ones` & ~`sel_remote_lb`. Remote loopback, whether manual or network-initiated, overrides the all-ones request.
- R8: `ctl_local_lb`=1 with `ctl_remote_lb`=1 and `ctl_all_ones`=0 resets `armed`, `net_active`, the arming sequence and both windows at the next edge. While both loopback bits are 1, neither loopback select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe: `rx_bit` holds a new recovered bit |
| rx_bit | input | 1 | Recovered line bit |
| ctl_wr | input | 1 | One-cycle strobe marking a control update |
| ctl_all_ones | input | 1 | Transmit-all-ones request level |
| ctl_local_lb | input | 1 | Manual local loopback level |
| ctl_remote_lb | input | 1 | Manual remote loopback level |
| armed | output | 1 | Code detection is armed |
| net_active | output | 1 | Network-commanded loopback is latched |
| sel_local_lb | output | 1 | Final local loopback select |
| sel_remote_lb | output | 1 | Final remote loopback select |
| sel_all_ones | output | 1 | Final transmit-all-ones select |

## Verification
The hardest state to reach from the ports is a window that passes while it carries errors. Each flipped bit counts as two mismatches, one at the flip and one a code length later, and it also shifts the count of ones. The bench therefore injects one flip per window length, which keeps every window at two mismatches and one extra or missing one. It then checks that qualification still succeeds, and that a flip every 7 bits never qualifies. The suspend path is reached by raising local loopback while a network loopback is latched, then dropping it with no new code on the line.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

   typedef enum logic [1:0] {
      ARM_IDLE   = 2'd0,
      ARM_PRIMED = 2'd1,
      ARM_ON     = 2'd2
   } arm_state_t;

   function automatic int count_ones(input logic [7:0] v);
      int n;
      n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      return n;
   endfunction

endpackage

// File: rtl/lpd_bit_history.sv
module lpd_bit_history #(
   parameter int DEPTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             rx_bit,
   output logic [DEPTH-1:0] taps
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("lpd_bit_history: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      taps <= '0;
            else if (bit_en) taps <= rx_bit;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      taps <= '0;
            else if (bit_en) taps <= {taps[DEPTH-2:0], rx_bit};
         end
      end
   endgenerate

   // R2: the newest tap always holds the last strobed bit
   assert_tap_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |=> taps[0] == $past(rx_bit));

endmodule

// File: rtl/lpd_code_window.sv
module lpd_code_window #(
   parameter int          CODE_LEN  = 5,
   parameter logic [7:0]  CODE_PAT  = 8'b0000_0001,
   parameter int          WIN_LEN   = 7_720_005,
   parameter int          ERR_LIMIT = 7_720
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic tap_bit,
   output logic hit
);

   localparam int CW       = $clog2(WIN_LEN + 1);
   localparam int ONES_EXP = (WIN_LEN / CODE_LEN) * lpd_pkg::count_ones(CODE_PAT);
   localparam int ONES_LO  = ONES_EXP - ERR_LIMIT;
   localparam int ONES_HI  = ONES_EXP + ERR_LIMIT;

   generate
      if (WIN_LEN % CODE_LEN != 0) begin : g_bad_win
         $error("lpd_code_window: WIN_LEN must be a multiple of CODE_LEN");
      end
      if (ERR_LIMIT < 0 || ERR_LIMIT >= WIN_LEN) begin : g_bad_lim
         $error("lpd_code_window: ERR_LIMIT out of range");
      end
   endgenerate

   logic [CW-1:0] bit_cnt, ones_cnt;
   logic [CW:0]   ones_tot;
   logic          mis, over, last, ones_ok, restart;

   assign mis      = rx_bit ^ tap_bit;
   assign last     = (bit_cnt == CW'(WIN_LEN - 1));
   assign ones_tot = {1'b0, ones_cnt} + {{CW{1'b0}}, rx_bit};
   assign ones_ok  = (int'(ones_tot) >= ONES_LO) && (int'(ones_tot) <= ONES_HI);
   assign restart  = bit_en & (over | last);
   assign hit      = run & bit_en & ~over & last & ones_ok;

   generate
      if (ERR_LIMIT == 0) begin : g_strict
         assign over = mis;
      end else begin : g_tolerant
         localparam int EW = $clog2(ERR_LIMIT + 2);
         logic [EW-1:0] err_cnt;

         assign over = (int'(err_cnt) + int'(mis)) > ERR_LIMIT;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                err_cnt <= '0;
            else if (!run || restart)  err_cnt <= '0;
            else if (bit_en)           err_cnt <= err_cnt + EW'(mis);
         end

         // R3: the mismatch count never passes the tolerated limit
         assert_err_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
            int'(err_cnt) <= ERR_LIMIT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         ones_cnt <= '0;
      end else if (!run || restart) begin
         bit_cnt  <= '0;
         ones_cnt <= '0;
      end else if (bit_en) begin
         bit_cnt  <= bit_cnt + CW'(1);
         ones_cnt <= ones_tot[CW-1:0];
      end
   end

   // R2: the window position stays inside the window
   assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bit_cnt) < WIN_LEN);

   // R1: when detection is not running the window is held empty
   assert_idle_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> bit_cnt == '0);

endmodule

// File: rtl/lpd_arm_ctrl.sv
module lpd_arm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic wr_ones,
   input  logic wr_local,
   input  logic wr_remote,
   input  logic self_rst,
   output logic armed
);
   import lpd_pkg::*;

   arm_state_t st, st_nx;
   logic       all_set, all_clr;

   assign all_set = wr_ones & wr_local & wr_remote;
   assign all_clr = ~wr_ones & ~wr_local & ~wr_remote;

   always_comb begin
      st_nx = st;
      if (self_rst) begin
         st_nx = ARM_IDLE;
      end else if (st == ARM_ON) begin
         if (wr_remote) st_nx = ARM_IDLE;
      end else if (ctl_wr) begin
         if (all_set)                          st_nx = ARM_PRIMED;
         else if (st == ARM_PRIMED && all_clr) st_nx = ARM_ON;
         else                                  st_nx = ARM_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ARM_IDLE;
      else        st <= st_nx;
   end

   assign armed = (st == ARM_ON);

   // R1: arming only follows a write that completes a primed sequence
   assert_arm_sequence_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(ctl_wr) && $past(st) == ARM_PRIMED);

endmodule

// File: rtl/inband_loop_detect.sv
module inband_loop_detect #(
   parameter int          WIN_LEN   = 7_720_005,
   parameter int          ERR_LIMIT = 7_720,
   parameter logic [7:0]  ACT_PAT   = 8'b0000_0001,
   parameter int          ACT_LEN   = 5,
   parameter logic [7:0]  DEACT_PAT = 8'b0000_0001,
   parameter int          DEACT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic ctl_wr,
   input  logic ctl_all_ones,
   input  logic ctl_local_lb,
   input  logic ctl_remote_lb,
   output logic armed,
   output logic net_active,
   output logic sel_local_lb,
   output logic sel_remote_lb,
   output logic sel_all_ones
);

   localparam int HIST_DEPTH = (ACT_LEN > DEACT_LEN) ? ACT_LEN : DEACT_LEN;

   generate
      if (ACT_LEN < 1 || ACT_LEN > 8 || DEACT_LEN < 1 || DEACT_LEN > 8) begin : g_bad_len
         $error("inband_loop_detect: code lengths must be 1 to 8");
      end
   endgenerate

   logic                  self_rst, run, act_hit, deact_hit;
   logic [HIST_DEPTH-1:0] taps;

   assign self_rst = ctl_local_lb & ctl_remote_lb & ~ctl_all_ones;
   assign run      = armed & ~ctl_remote_lb;

   lpd_arm_ctrl u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .wr_ones   (ctl_all_ones),
      .wr_local  (ctl_local_lb),
      .wr_remote (ctl_remote_lb),
      .self_rst  (self_rst),
      .armed     (armed)
   );

   lpd_bit_history #(.DEPTH(HIST_DEPTH)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .rx_bit (rx_bit),
      .taps   (taps)
   );

   lpd_code_window #(
      .CODE_LEN (ACT_LEN),
      .CODE_PAT (ACT_PAT),
      .WIN_LEN  (WIN_LEN),
      .ERR_LIMIT(ERR_LIMIT)
   ) u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .bit_en  (bit_en),
      .rx_bit  (rx_bit),
      .tap_bit (taps[ACT_LEN-1]),
      .hit     (act_hit)
   );

   lpd_code_window #(
      .CODE_LEN (DEACT_LEN),
      .CODE_PAT (DEACT_PAT),
      .WIN_LEN  (WIN_LEN),
      .ERR_LIMIT(ERR_LIMIT)
   ) u_deact (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .bit_en  (bit_en),
      .rx_bit  (rx_bit),
      .tap_bit (taps[DEACT_LEN-1]),
      .hit     (deact_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   net_active <= 1'b0;
      else if (self_rst || ctl_remote_lb || !armed) net_active <= 1'b0;
      else if (deact_hit)                           net_active <= 1'b0;
      else if (act_hit)                             net_active <= 1'b1;
   end

   assign sel_local_lb  = ctl_local_lb & ~ctl_remote_lb;
   assign sel_remote_lb = ~ctl_local_lb & (ctl_remote_lb | net_active);
   assign sel_all_ones  = ctl_all_ones & ~sel_remote_lb;

   // R8: the conflicting loopback pair clears the latched state
   assert_self_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      self_rst |=> !armed && !net_active);

   // R5: manual remote loopback disarms and drops the network loopback
   assert_manual_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ctl_remote_lb) |=> !armed && !net_active);

   // R5: a network loopback never outlives arming
   assert_net_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      net_active |-> armed);

   // R2: a qualified activate window latches the loopback
   assert_act_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && act_hit && !deact_hit) |=> net_active);

   // R6: local loopback alone leaves the network loopback latched
   assert_suspend_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (net_active && ctl_local_lb && !ctl_remote_lb && !deact_hit) |=> net_active);

endmodule

// File: tb/tb_inband_loop_detect.sv
`timescale 1ns/1ps
module tb_inband_loop_detect;

   localparam int WIN = 60;
   localparam int LIM = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, rx_bit = 1'b0, ctl_wr = 1'b0;
   logic ctl_all_ones = 1'b0, ctl_local_lb = 1'b0, ctl_remote_lb = 1'b0;
   logic armed, net_active, sel_local_lb, sel_remote_lb, sel_all_ones;

   int n_checks = 0;
   int n_fail   = 0;
   bit go       = 1'b0;

   always #2.5 clk = ~clk;

   inband_loop_detect #(.WIN_LEN(WIN), .ERR_LIMIT(LIM)) dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .ctl_wr(ctl_wr),
      .ctl_all_ones(ctl_all_ones), .ctl_local_lb(ctl_local_lb), .ctl_remote_lb(ctl_remote_lb),
      .armed(armed), .net_active(net_active), .sel_local_lb(sel_local_lb),
      .sel_remote_lb(sel_remote_lb), .sel_all_ones(sel_all_ones)
   );

   // behavioural reference: 0 idle, 1 primed, 2 armed
   int m_state = 0;
   bit m_net   = 1'b0;
   bit mh[$]   = '{0, 0, 0, 0, 0};
   int m_cnt[2]  = '{0, 0};
   int m_err[2]  = '{0, 0};
   int m_ones[2] = '{0, 0};
   int clen[2]   = '{5, 3};
   int cexp[2]   = '{WIN / 5, WIN / 3};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_net = 1'b0; mh = '{0, 0, 0, 0, 0};
         m_cnt = '{0, 0}; m_err = '{0, 0}; m_ones = '{0, 0};
      end else begin
         bit hitk[2];
         bit srst, runm;
         srst = ctl_local_lb && ctl_remote_lb && !ctl_all_ones;
         runm = (m_state == 2) && !ctl_remote_lb;
         for (int k = 0; k < 2; k++) begin
            hitk[k] = 1'b0;
            if (!runm) begin
               m_cnt[k] = 0; m_err[k] = 0; m_ones[k] = 0;
            end else if (bit_en) begin
               int mis, d;
               mis = (rx_bit != mh[clen[k]-1]) ? 1 : 0;
               if (m_err[k] + mis > LIM) begin
                  m_cnt[k] = 0; m_err[k] = 0; m_ones[k] = 0;
               end else if (m_cnt[k] == WIN - 1) begin
                  d = m_ones[k] + int'(rx_bit) - cexp[k];
                  hitk[k] = (d <= LIM) && (d >= -LIM);
                  m_cnt[k] = 0; m_err[k] = 0; m_ones[k] = 0;
               end else begin
                  m_cnt[k]++; m_err[k] += mis; m_ones[k] += int'(rx_bit);
               end
            end
         end
         if (srst || ctl_remote_lb || m_state != 2) m_net = 1'b0;
         else if (hitk[1])                           m_net = 1'b0;
         else if (hitk[0])                           m_net = 1'b1;
         if (srst) m_state = 0;
         else if (m_state == 2) begin
            if (ctl_remote_lb) m_state = 0;
         end else if (ctl_wr) begin
            if (ctl_all_ones && ctl_local_lb && ctl_remote_lb) m_state = 1;
            else if (m_state == 1 && !ctl_all_ones && !ctl_local_lb && !ctl_remote_lb) m_state = 2;
            else m_state = 0;
         end
         if (bit_en) begin
            mh.push_front(rx_bit);
            void'(mh.pop_back());
         end
      end
   end

   task automatic cmp(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      #1;
      if (rst_n && go) begin
         bit e_rem;
         e_rem = !ctl_local_lb && (ctl_remote_lb || m_net);
         cmp("R1 armed vs model", armed, m_state == 2);
         cmp("R2 net_active vs model", net_active, m_net);
         cmp("R6 sel_local_lb vs model", sel_local_lb, ctl_local_lb && !ctl_remote_lb);
         cmp("R6 sel_remote_lb vs model", sel_remote_lb, e_rem);
         cmp("R7 sel_all_ones vs model", sel_all_ones, ctl_all_ones && !e_rem);
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      #1;
      cmp(tag, act, exp);
   endtask

   task automatic wr(input logic t, input logic l, input logic r);
      @(negedge clk);
      ctl_all_ones = t; ctl_local_lb = l; ctl_remote_lb = r; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic send_code(input logic [7:0] pat, input int len, input int nbits, input int flip_every);
      for (int i = 0; i < nbits; i++) begin
         logic b;
         b = pat[len - 1 - (i % len)];
         if (flip_every > 0 && (i % flip_every) == flip_every - 1) b = ~b;
         @(negedge clk);
         bit_en = 1'b1; rx_bit = b;
         @(negedge clk);
         bit_en = 1'b0;
      end
   endtask

   task automatic arm();
      wr(1'b1, 1'b1, 1'b1);
      wr(1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1-path run did not finish actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      go = 1'b1;
      chk("R1 reset armed", armed, 1'b0);
      chk("R2 reset net_active", net_active, 1'b0);
      chk("R7 reset sel_all_ones", sel_all_ones, 1'b0);

      // R1: codes ignored while not armed
      send_code(8'b0000_0001, 5, 3 * WIN, 0);
      chk("R1 unarmed code ignored", net_active, 1'b0);

      // R1: an interleaved write cancels the sequence
      wr(1'b1, 1'b1, 1'b1);
      chk("R8 prime write selects no loopback", sel_remote_lb | sel_local_lb, 1'b0);
      wr(1'b1, 1'b0, 1'b0);
      wr(1'b0, 1'b0, 1'b0);
      chk("R1 cancelled sequence", armed, 1'b0);

      arm();
      chk("R1 armed after sequence", armed, 1'b1);

      // R2: all zeros never qualify
      send_code(8'b0000_0000, 5, 3 * WIN, 0);
      chk("R2 zeros do not activate", net_active, 1'b0);

      // R3: dense errors never qualify, sparse errors do
      send_code(8'b0000_0001, 5, 5 * WIN, 7);
      chk("R3 dense errors rejected", net_active, 1'b0);
      send_code(8'b0000_0001, 5, 5 * WIN, WIN);
      chk("R3 sparse errors tolerated", net_active, 1'b1);
      chk("R2 remote select from network", sel_remote_lb, 1'b1);

      // R7: loopback overrides all-ones
      wr(1'b1, 1'b0, 1'b0);
      chk("R7 all-ones overridden", sel_all_ones, 1'b0);

      // R6: local loopback suspends without clearing
      wr(1'b1, 1'b1, 1'b0);
      chk("R6 suspended remote select", sel_remote_lb, 1'b0);
      chk("R6 local select", sel_local_lb, 1'b1);
      chk("R6 net kept while suspended", net_active, 1'b1);
      chk("R7 all-ones while suspended", sel_all_ones, 1'b1);
      wr(1'b0, 1'b0, 1'b0);
      chk("R6 resumed remote select", sel_remote_lb, 1'b1);

      // R4: deactivate code releases, arming stays
      send_code(8'b0000_0001, 3, 3 * WIN, 0);
      chk("R4 deactivate clears net", net_active, 1'b0);
      chk("R4 still armed", armed, 1'b1);

      // R5: manual remote loopback clears and disarms
      send_code(8'b0000_0001, 5, 3 * WIN, 0);
      chk("R2 reactivated", net_active, 1'b1);
      wr(1'b0, 1'b0, 1'b1);
      chk("R5 net cleared", net_active, 1'b0);
      chk("R5 disarmed", armed, 1'b0);
      chk("R5 manual remote select", sel_remote_lb, 1'b1);
      wr(1'b0, 1'b0, 1'b0);
      send_code(8'b0000_0001, 5, 3 * WIN, 0);
      chk("R5 disarmed ignores code", net_active, 1'b0);

      // R8: conflicting loopbacks reset the block
      arm();
      send_code(8'b0000_0001, 5, 3 * WIN, 0);
      chk("R8 precondition active", net_active, 1'b1);
      wr(1'b0, 1'b1, 1'b1);
      chk("R8 armed cleared", armed, 1'b0);
      chk("R8 net cleared", net_active, 1'b0);
      chk("R8 no local select", sel_local_lb, 1'b0);
      chk("R8 no remote select", sel_remote_lb, 1'b0);
      wr(1'b0, 1'b0, 1'b0);
      chk("R8 stays disarmed", armed, 1'b0);

      repeat (4) @(negedge clk);
      go = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule